// File: doc/BRIEF.md
# Lookahead Single-Rail Pipeline Stage

This block is one stage of a bundled-data pipeline meant to be chained into a FIFO. It is modelled synchronously. Each stage has a precharge/evaluate phase, driven by two lookahead controls. The first, `pc_in`, comes from the next stage. The second, `eval_in`, comes from the stage two places ahead. Together they let a stage leave precharge as soon as the stage two ahead has taken its token, instead of waiting for the next stage to drain.

A stage enters evaluate and sees a valid request. It then latches the incoming word and raises an internal done flag at once. That flag is brought out directly as the acknowledge to earlier stages, because an evaluating or precharged stage no longer reacts to its inputs. The outgoing request follows done through a matched delay, a tick counter whose length is a parameter standing in for the datapath evaluation time. Precharge clears done and the outgoing request together.

In a chain, stage k takes `pc_in` from the acknowledge of stage k+1 and `eval_in` from the acknowledge of stage k+2.

Top module: `lkahead_sr_stage`

## Requirements
- R1: While `rst_n` is low, `ack_out` and `req_out` are 0 and `data_out` is all zeros.
- R2: The stage is in evaluate when `pc_in` is 0 or `eval_in` is 1, and in precharge only when `pc_in` is 1 and `eval_in` is 0.
- R3: At the first rising clock edge where the stage is in evaluate and `req_in` is 1, `ack_out` becomes 1. With `req_in` at 0, `ack_out` stays 0.
- R4: At the first rising edge where the stage is in precharge, `ack_out` becomes 0, whatever `req_in` is.
- R5: While in evaluate with `ack_out` at 1, changes on `req_in` and `data_in` change neither `ack_out` nor `data_out`.
- R6: `req_out` becomes 1 exactly DELAY rising edges after the edge where `ack_out` rose. With DELAY = 0 it rises on that same edge.
- R7: `req_out` returns to 0 on the same edge where `ack_out` returns to 0.
- R8: `data_out` takes the value of `data_in` at the edge where `ack_out` rises, and holds it while `ack_out` stays 1.
- R9: `req_out` is never 1 while `ack_out` is 0. With DELAY > 0, `ack_out` is 1 for DELAY cycles before `req_out` is 1.
- R10: With LOOKAHEAD = 0, `eval_in` is ignored: the stage evaluates exactly when `pc_in` is 0.
- R11: Ten chained stages deliver every token once, in order and with its data intact, to a sink that stalls at random.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick of the matched delay |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 1 | Request from the previous stage (bundled with `data_in`) |
| data_in | input | WIDTH | Data word from the previous stage |
| pc_in | input | 1 | Done of the next stage; requests precharge |
| eval_in | input | 1 | Done of the stage two ahead; forces early evaluation |
| ack_out | output | 1 | Early acknowledge (the stage's done) to earlier stages |
| req_out | output | 1 | Delayed request to the next stage |
| data_out | output | WIDTH | Latched data word to the next stage |

## Verification
Two functions can coincide: the early-evaluation hold and the precharge request. Both can be active when `pc_in` rises while `eval_in` is already 1 and `ack_out` is 1. The bench drives exactly that combination, with a changed `data_in` and `req_in`. It expects `ack_out`, `req_out` and `data_out` to stay as they were, and it expects precharge on the first cycle after `eval_in` drops. In the ten-stage chain, the same overlap arises on its own under random sink stalls. There, a scoreboard judges the outcome by the order and values of the tokens reaching the sink.

// File: rtl/lkahead_pkg.sv
package lkahead_pkg;
   typedef enum logic {
      PH_PRECHARGE = 1'b0,
      PH_EVALUATE  = 1'b1
   } phase_e;

   localparam int MAX_DELAY = 4095;
   localparam int MAX_WIDTH = 1024;
endpackage

// File: rtl/lkahead_ctl_merge.sv
module lkahead_ctl_merge
   import lkahead_pkg::*;
#(
   parameter int LOOKAHEAD = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pc,
   input  logic   ev,
   output phase_e phase
);
   localparam logic LA_EN = (LOOKAHEAD != 0);

   // NAND merge: precharge only when pc high and lookahead eval low
   logic go_eval;
   assign go_eval = ~(pc & ~(ev & LA_EN));
   assign phase   = go_eval ? PH_EVALUATE : PH_PRECHARGE;

   AST_PC_LOW_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
      !pc |-> phase == PH_EVALUATE); // R2
endmodule

// File: rtl/lkahead_done_celem.sv
module lkahead_done_celem
   import lkahead_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e phase,
   input  logic   req,
   output logic   done,
   output logic   fire
);
   logic done_q;

   assign fire = (phase == PH_EVALUATE) && req && !done_q;

   // asymmetric C-element: set needs evaluate and request, reset needs precharge
   always_ff @(posedge clk) begin
      if (!rst_n)                     done_q <= 1'b0;
      else if (phase == PH_PRECHARGE) done_q <= 1'b0;
      else if (req)                   done_q <= 1'b1;
   end

   assign done = done_q;

   AST_SET_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EVALUATE && req) |=> done); // R3
   AST_CLR_ON_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PRECHARGE) |=> !done); // R4
   AST_HOLD_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EVALUATE && done) |=> done); // R5
endmodule

// File: rtl/lkahead_match_delay.sv
module lkahead_match_delay #(
   parameter int DELAY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   output logic req_out
);
   localparam int CW = (DELAY > 1) ? $clog2(DELAY + 1) : 1;

   generate
      if (DELAY == 0) begin : g_direct
         assign req_out = done;
         AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done) |-> req_out); // R6
      end else begin : g_count
         logic [CW-1:0] tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !done)         tick_q <= '0;
            else if (tick_q != CW'(DELAY)) tick_q <= tick_q + 1'b1;
         end
         assign req_out = done && (tick_q == CW'(DELAY));
         AST_NOT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done) |-> !req_out); // R9
      end
   endgenerate

   AST_REQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> !req_out); // R7
endmodule

// File: rtl/lkahead_sr_stage.sv
module lkahead_sr_stage
   import lkahead_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int DELAY     = 3,
   parameter int LOOKAHEAD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_in,
   input  logic [WIDTH-1:0] data_in,
   input  logic             pc_in,
   input  logic             eval_in,
   output logic             ack_out,
   output logic             req_out,
   output logic [WIDTH-1:0] data_out
);
   generate
      if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("lkahead_sr_stage: WIDTH out of range");
      end
      if (DELAY < 0 || DELAY > MAX_DELAY) begin : g_bad_delay
         $error("lkahead_sr_stage: DELAY out of range");
      end
      if (LOOKAHEAD != 0 && LOOKAHEAD != 1) begin : g_bad_la
         $error("lkahead_sr_stage: LOOKAHEAD must be 0 or 1");
      end
   endgenerate

   phase_e           phase;
   logic             done;
   logic             fire;
   logic [WIDTH-1:0] word_q;

   lkahead_ctl_merge #(.LOOKAHEAD(LOOKAHEAD)) u_merge (
      .clk(clk), .rst_n(rst_n), .pc(pc_in), .ev(eval_in), .phase(phase));

   lkahead_done_celem u_celem (
      .clk(clk), .rst_n(rst_n), .phase(phase), .req(req_in),
      .done(done), .fire(fire));

   lkahead_match_delay #(.DELAY(DELAY)) u_delay (
      .clk(clk), .rst_n(rst_n), .done(done), .req_out(req_out));

   // capture on the evaluation start; held through evaluate and precharge
   always_ff @(posedge clk) begin
      if (!rst_n)    word_q <= '0;
      else if (fire) word_q <= data_in;
   end

   assign data_out = word_q;
   assign ack_out  = done;   // acknowledge tapped off before the delay

   AST_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      req_out |-> ack_out); // R9
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_out && $past(ack_out)) |-> $stable(data_out)); // R8
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!ack_out && !req_out)); // R1
endmodule

// File: tb/lkahead_sr_stage_tb.sv
module lkahead_sr_stage_tb;
   localparam int NTOK   = 60;
   localparam int NSTAGE = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   logic finished = 1'b0;

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // main stage under test, DELAY 3
   logic pc, ev, rq;
   logic [7:0] din, dout;
   logic ack, rqo;
   lkahead_sr_stage #(.WIDTH(8), .DELAY(3), .LOOKAHEAD(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_in(rq), .data_in(din), .pc_in(pc),
      .eval_in(ev), .ack_out(ack), .req_out(rqo), .data_out(dout));

   // variant without lookahead, DELAY 0
   logic n_pc, n_ev, n_rq, n_ack, n_rqo;
   logic [7:0] n_din, n_dout;
   lkahead_sr_stage #(.WIDTH(8), .DELAY(0), .LOOKAHEAD(0)) u_nola (
      .clk(clk), .rst_n(rst_n), .req_in(n_rq), .data_in(n_din), .pc_in(n_pc),
      .eval_in(n_ev), .ack_out(n_ack), .req_out(n_rqo), .data_out(n_dout));

   // ten-stage chain
   logic       src_req, snk_done;
   logic [7:0] src_data;
   logic       c_req  [0:NSTAGE];
   logic [7:0] c_data [0:NSTAGE];
   logic       c_ack  [0:NSTAGE+1];
   assign c_req[0]         = src_req;
   assign c_data[0]        = src_data;
   assign c_ack[NSTAGE]    = snk_done;
   assign c_ack[NSTAGE+1]  = 1'b0;
   for (genvar g = 0; g < NSTAGE; g++) begin : g_chain
      lkahead_sr_stage #(.WIDTH(8), .DELAY(2), .LOOKAHEAD(1)) u_stg (
         .clk(clk), .rst_n(rst_n), .req_in(c_req[g]), .data_in(c_data[g]),
         .pc_in(c_ack[g+1]), .eval_in(c_ack[g+2]), .ack_out(c_ack[g]),
         .req_out(c_req[g+1]), .data_out(c_data[g+1]));
   end

   logic [7:0] exp_q [0:NTOK-1];
   int n_rx = 0;

   task automatic t_reset();
      chk(!ack && !rqo && dout == 8'h00, "R1 ack/req/data in reset", {ack, rqo, dout}, 0);
   endtask

   task automatic t_precharge_blocks();
      pc = 1; ev = 0; rq = 1; din = 8'h11;
      tick(); tick(); tick();
      chk(!ack, "R2 precharge blocks request", ack, 0);
   endtask

   task automatic t_fire_and_delay();
      pc = 0; din = 8'hA5;
      tick();
      chk(ack, "R3 ack rises on evaluate+req", ack, 1);
      chk(!rqo, "R9 ack precedes req", rqo, 0);
      chk(dout == 8'hA5, "R8 data captured", dout, 8'hA5);
      rq = 0; din = 8'h3C;
      tick();
      chk(!rqo, "R6 req low after 1 tick", rqo, 0);
      tick();
      chk(!rqo, "R6 req low after 2 ticks", rqo, 0);
      tick();
      chk(rqo, "R6 req high after DELAY ticks", rqo, 1);
      chk(ack && dout == 8'hA5, "R5 input change ignored", dout, 8'hA5);
   endtask

   task automatic t_overlap_hold();
      pc = 1; ev = 1; rq = 1; din = 8'h77;
      tick(); tick();
      chk(ack && rqo, "R2 lookahead keeps evaluate", {ack, rqo}, 2'b11);
      chk(dout == 8'hA5, "R5 data held under overlap", dout, 8'hA5);
      ev = 0;
      tick();
      chk(!ack, "R4 precharge clears ack", ack, 0);
      chk(!rqo, "R7 req falls with ack", rqo, 0);
   endtask

   task automatic t_lookahead_fire();
      pc = 1; ev = 1; rq = 1; din = 8'h5A;
      tick();
      chk(ack && dout == 8'h5A, "R2 early evaluation takes token", dout, 8'h5A);
      ev = 0;
      tick();
      chk(!ack, "R4 precharge again", ack, 0);
      pc = 0; rq = 0;
      tick(); tick();
      chk(!ack, "R3 no request no ack", ack, 0);
   endtask

   task automatic t_no_lookahead();
      n_pc = 1; n_ev = 1; n_rq = 1; n_din = 8'hC3;
      tick();
      chk(!n_ack, "R10 eval_in ignored", n_ack, 0);
      n_pc = 0;
      tick();
      chk(n_ack && n_rqo, "R6 zero delay req with ack", {n_ack, n_rqo}, 2'b11);
      chk(n_dout == 8'hC3, "R8 data captured no-lookahead", n_dout, 8'hC3);
      n_pc = 1;
      tick();
      chk(!n_ack && !n_rqo, "R10 precharge despite eval_in", {n_ack, n_rqo}, 0);
   endtask

   task automatic t_chain();
      fork
         begin
            for (int i = 0; i < NTOK; i++) begin
               exp_q[i] = 8'($urandom);
               src_data = exp_q[i];
               src_req  = 1;
               while (!c_ack[0]) tick();
               src_req = 0;
               while (c_ack[0]) tick();
            end
         end
         begin
            while (n_rx < NTOK) begin
               if ($urandom_range(0, 2) != 0) begin
                  if (c_req[NSTAGE] && !snk_done) begin
                     chk(c_data[NSTAGE] == exp_q[n_rx], "R11 chain order/data",
                         c_data[NSTAGE], exp_q[n_rx]);
                     n_rx++;
                     snk_done = 1;
                  end else if (!c_req[NSTAGE] && snk_done) begin
                     snk_done = 0;
                  end
               end
               tick();
            end
         end
      join
      repeat (30) tick();
      chk(!c_req[NSTAGE] || snk_done, "R11 no extra token", c_req[NSTAGE], 0);
   endtask

   initial begin
      pc = 1; ev = 0; rq = 0; din = 0;
      n_pc = 1; n_ev = 0; n_rq = 0; n_din = 0;
      src_req = 0; src_data = 0; snk_done = 0;
      tick(); tick();
      t_reset();
      rst_n = 1;
      tick();
      t_precharge_blocks();
      t_fire_and_delay();
      t_overlap_hold();
      t_lookahead_fire();
      t_no_lookahead();
      t_chain();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule